// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block walks a converter through a set of enabled input channels in continuous conversion mode. A channel-enable mask picks the channels. The block visits them from the lowest index upward and wraps around. Each time it selects a channel, it pulses a filter/modulator reset. It then counts output-rate ticks from an abstract converter model until a full settling interval has passed. After that it latches the converter's data word into a result register and pulses an active-low ready flag.

The result register can carry a status byte after the data word. That byte names the channel the data came from, so the host can tell interleaved results apart. The host reads the previous result while the next channel settles. The register stays unchanged until the next publication.

With only one channel enabled, the filter is not reset between results. One result then appears per tick once the first interval has settled. If the mask changes, the sequence restarts from the lowest enabled channel. A change that interrupts a partly counted interval is flagged in the next status byte. An all-zero mask leaves the block idle.

Top module: `conv_sequencer`

## Requirements
- R1: `chan_sel` only ever names a channel whose enable bit is set in the mask currently in force. Enable bit i stands for channel index i.
- R2: The first channel selected after reset or after a mask change is the lowest enabled index. Later channels follow in ascending index order and wrap from the highest enabled index back to the lowest.
- R3: Every selection of a new channel drives `filt_rst` high for exactly one clock cycle. `rdy_n` is high in the following cycle and stays high until the next publication.
- R4: A result is published on the clock edge that samples the SETTLE_TICKS-th `rate_tick` counted after the filter reset (4 by default). `rdy_n` is low for exactly the one cycle after that edge. The published data is the `conv_data` present together with that tick.
- R5: With exactly one channel enabled, after the first full settling interval, every further `rate_tick` publishes a new result and no further filter reset occurs.
- R6: With an all-zero mask, `rdy_n` stays high, `filt_rst` stays low and no result is published, whatever `rate_tick` does. Out of reset, `rdy_n` is 1, `filt_rst` is 0, and `result` and `chan_sel` are 0.
- R7: `result` changes only in the cycle in which `rdy_n` is low. In that same cycle `chan_sel` already names the next enabled channel.
- R8: With `status_en` low, `result` is {8'h00, data}. With `status_en` high, `result` is {data, status}, where status bit 7 is the error flag, bits 6:3 are zero and bits 2:0 are the channel index.
- R9: A change of the mask to a non-zero value restarts the sequence, with a filter reset in the next cycle, and discards any ticks already counted. If at least one tick of the current interval had been counted, the error flag is set in the next published status byte and cleared after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 8 | Channel-enable mask, bit i enables channel i |
| rate_tick | input | 1 | One-cycle strobe per converter output-rate period |
| conv_data | input | 24 | Converter data word, valid with `rate_tick` |
| status_en | input | 1 | Append the status byte to the result |
| chan_sel | output | 3 | Index of the selected channel |
| filt_rst | output | 1 | One-cycle filter/modulator reset pulse |
| result | output | 32 | Published result word |
| rdy_n | output | 1 | Active-low one-cycle ready pulse |

## Verification
The bench builds the block with its default parameters: eight channels, a 24-bit data word and a four-tick settling interval. Eight channels make the full 3-bit index and the wrap from a high channel back to a low one observable. Four ticks let twelve ticks per vector span three complete intervals, so three channels in sequence can be checked. The short interval also lets a two-tick partial count be interrupted by a mask change and compared against a full restart.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRST   = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;

    localparam int STATUS_W = 8;
endpackage

// File: rtl/conv_seq_picker.sv
// Finds the first set mask bit strictly after index start_idx, wrapping.
// With start_idx = NCH-1 this yields the lowest set bit; a lone set bit at
// start_idx is found again on the last step (i = NCH wraps to start_idx).
module conv_seq_picker #(
    parameter int NCH   = 8,
    parameter int IDX_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]   mask,
    input  logic [IDX_W-1:0] start_idx,
    output logic [IDX_W-1:0] pick_idx
);
    always_comb begin
        logic             found;
        logic [IDX_W-1:0] cand;
        found    = 1'b0;
        pick_idx = start_idx;
        for (int i = 1; i <= NCH; i++) begin
            cand = start_idx + IDX_W'(i);
            if (!found && mask[cand]) begin
                found    = 1'b1;
                pick_idx = cand;
            end
        end
    end
endmodule

// File: rtl/conv_seq_packer.sv
// Forms the result word: data alone, or data followed by a status byte.
module conv_seq_packer #(
    parameter int DATA_W = 24,
    parameter int IDX_W  = 3,
    localparam int RES_W = DATA_W + conv_seq_pkg::STATUS_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              err,
    input  logic              with_status,
    output logic [RES_W-1:0]  word
);
    localparam int SW = conv_seq_pkg::STATUS_W;

    logic [SW-1:0] status;

    always_comb begin
        status          = '0;
        status[SW-1]    = err;
        status[IDX_W-1:0] = idx;
        if (with_status) word = {data, status};
        else             word = {{SW{1'b0}}, data};
    end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
    parameter int NCH          = 8,
    parameter int DATA_W       = 24,
    parameter int SETTLE_TICKS = 4,
    localparam int IDX_W       = $clog2(NCH),
    localparam int CNT_W       = $clog2(SETTLE_TICKS + 1),
    localparam int RES_W       = DATA_W + conv_seq_pkg::STATUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_en,
    input  logic              rate_tick,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              status_en,
    output logic [IDX_W-1:0]  chan_sel,
    output logic              filt_rst,
    output logic [RES_W-1:0]  result,
    output logic              rdy_n
);
    import conv_seq_pkg::*;

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_TICKS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [NCH-1:0]   mask;
        logic [IDX_W-1:0] cur;
        logic [CNT_W-1:0] cnt;
        logic             err;
        logic             frst;
        logic             rdy_n;
        logic [RES_W-1:0] res;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [IDX_W-1:0] low_idx;
    logic [IDX_W-1:0] next_idx;
    logic [RES_W-1:0] packed_word;
    logic             mask_chg;

    conv_seq_picker #(.NCH(NCH), .IDX_W(IDX_W)) u_pick_low (
        .mask      (chan_en),
        .start_idx ({IDX_W{1'b1}}),
        .pick_idx  (low_idx)
    );

    conv_seq_picker #(.NCH(NCH), .IDX_W(IDX_W)) u_pick_next (
        .mask      (q.mask),
        .start_idx (q.cur),
        .pick_idx  (next_idx)
    );

    conv_seq_packer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pack (
        .data        (conv_data),
        .idx         (q.cur),
        .err         (q.err),
        .with_status (status_en),
        .word        (packed_word)
    );

    assign mask_chg = (chan_en != q.mask);

    always_comb begin
        d       = q;
        d.frst  = 1'b0;
        d.rdy_n = 1'b1;
        if (mask_chg) begin
            d.mask = chan_en;
            d.cnt  = '0;
            if (q.st == ST_SETTLE && q.cnt != '0) d.err = 1'b1;
            if (chan_en == '0) begin
                d.st = ST_IDLE;
            end else begin
                d.st   = ST_FRST;
                d.cur  = low_idx;
                d.frst = 1'b1;
            end
        end else begin
            case (q.st)
                ST_FRST: begin
                    d.st  = ST_SETTLE;
                    d.cnt = '0;
                end
                ST_SETTLE: begin
                    if (rate_tick) begin
                        if (q.cnt == LAST_CNT) begin
                            d.res   = packed_word;
                            d.rdy_n = 1'b0;
                            d.err   = 1'b0;
                            if (next_idx != q.cur) begin
                                d.cur  = next_idx;
                                d.st   = ST_FRST;
                                d.frst = 1'b1;
                                d.cnt  = '0;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.mask  <= '0;
            q.cur   <= '0;
            q.cnt   <= '0;
            q.err   <= 1'b0;
            q.frst  <= 1'b0;
            q.rdy_n <= 1'b1;
            q.res   <= '0;
        end else begin
            q <= d;
        end
    end

    assign chan_sel = q.cur;
    assign filt_rst = q.frst;
    assign result   = q.res;
    assign rdy_n    = q.rdy_n;

    // R1
    chan_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> q.mask[q.cur]);

    // R3
    rdy_high_after_frst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst |=> rdy_n);

    // R4
    rdy_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |=> rdy_n);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (rdy_n && !filt_rst));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> !rdy_n);

    // R9
    restart_frst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_chg && chan_en != '0) |=> filt_rst);
endmodule

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  chan_en = '0;
    logic        rate_tick = 1'b0;
    logic [23:0] conv_data = '0;
    logic        status_en = 1'b0;
    logic [2:0]  chan_sel;
    logic        filt_rst;
    logic [31:0] result;
    logic        rdy_n;

    int checks = 0;
    int errors = 0;
    int fr_tot = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    conv_sequencer dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rate_tick(rate_tick),
        .conv_data(conv_data), .status_en(status_en), .chan_sel(chan_sel),
        .filt_rst(filt_rst), .result(result), .rdy_n(rdy_n)
    );

    always @(negedge clk) if (rst_n && filt_rst) fr_tot++;

    typedef struct packed {
        logic [7:0] mask;
        logic       st;
        logic [2:0] c0;
        logic [2:0] c1;
        logic [2:0] c2;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{8'hA5, 1'b1, 3'd0, 3'd2, 3'd5},
        '{8'h80, 1'b0, 3'd7, 3'd7, 3'd7},
        '{8'h42, 1'b1, 3'd1, 3'd6, 3'd1},
        '{8'hFF, 1'b0, 3'd0, 3'd1, 3'd2}
    };

    function automatic logic [23:0] dat(input int t);
        return 24'h5A0000 | 24'(t);
    endfunction

    function automatic logic [31:0] expect_word(input int t, input logic st,
                                                input logic err, input logic [2:0] ch);
        if (st) return {dat(t), err, 4'b0000, ch};
        return {8'h00, dat(t)};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_tick(input int t);
        @(negedge clk);
        rate_tick = 1'b1;
        conv_data = dat(t);
        @(negedge clk);
        rate_tick = 1'b0;
        conv_data = 24'h0;
    endtask

    task automatic gap();
        repeat (3) @(negedge clk);
    endtask

    task automatic start(input logic [7:0] m, input logic s);
        @(negedge clk);
        rst_n     = 1'b0;
        chan_en   = m;
        status_en = s;
        rate_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] last;
        int          base;
        int          pubs;
        bit          single;
        bit          exp_pub;
        logic [2:0]  ch;

        // Reset state (R6)
        repeat (3) @(negedge clk);
        chk(rdy_n === 1'b1 && filt_rst === 1'b0, "R6 reset flags",
            {30'd0, rdy_n, filt_rst}, 32'h2);
        chk(result === 32'h0 && chan_sel === 3'd0, "R6 reset data",
            result, 32'h0);

        // Vector table (R2 R3 R4 R5 R7 R8)
        for (int v = 0; v < 4; v++) begin
            base = fr_tot;
            start(VEC[v].mask, VEC[v].st);
            chk(chan_sel == VEC[v].c0, "R2 first channel",
                {29'd0, chan_sel}, {29'd0, VEC[v].c0});
            single = ($countones(VEC[v].mask) == 1);
            pubs   = 0;
            last   = result;
            for (int t = 1; t <= 12; t++) begin
                do_tick(t);
                exp_pub = single ? (t >= 4) : (t % 4 == 0);
                if (exp_pub) begin
                    chk(rdy_n == 1'b0, "R4 ready pulse", {31'd0, rdy_n}, 32'd0);
                    if (single)         ch = VEC[v].c0;
                    else if (pubs == 0) ch = VEC[v].c0;
                    else if (pubs == 1) ch = VEC[v].c1;
                    else                ch = VEC[v].c2;
                    chk(result == expect_word(t, VEC[v].st, 1'b0, ch), "R2 R8 result",
                        result, expect_word(t, VEC[v].st, 1'b0, ch));
                    if (!single && pubs == 0)
                        chk(chan_sel == VEC[v].c1, "R7 next select",
                            {29'd0, chan_sel}, {29'd0, VEC[v].c1});
                    if (!single && pubs == 1)
                        chk(chan_sel == VEC[v].c2, "R7 next select",
                            {29'd0, chan_sel}, {29'd0, VEC[v].c2});
                    pubs++;
                    last = result;
                end else begin
                    chk(rdy_n == 1'b1 && result == last, "R7 hold", result, last);
                end
                gap();
                chk(rdy_n == 1'b1, "R4 one-cycle ready", {31'd0, rdy_n}, 32'd1);
            end
            // R3 one reset per selection; R5 none between single-channel results
            chk(fr_tot - base == (single ? 1 : 4), single ? "R5 resets" : "R3 resets",
                32'(fr_tot - base), single ? 32'd1 : 32'd4);
        end

        // All-zero mask (R6)
        base = fr_tot;
        start(8'h00, 1'b1);
        last = result;
        for (int t = 1; t <= 8; t++) begin
            do_tick(t);
            chk(rdy_n == 1'b1 && filt_rst == 1'b0 && result == last, "R6 idle",
                result, last);
        end
        chk(fr_tot == base, "R6 no reset", 32'(fr_tot - base), 32'd0);

        // Mask change mid-settling (R9)
        start(8'h03, 1'b1);
        do_tick(1); gap();
        do_tick(2); gap();
        @(negedge clk);
        chan_en = 8'h0C;
        @(negedge clk);
        chk(filt_rst == 1'b1 && chan_sel == 3'd2, "R9 restart",
            {28'd0, filt_rst, chan_sel}, {28'd0, 1'b1, 3'd2});
        last = result;
        for (int t = 3; t <= 10; t++) begin
            do_tick(t);
            if (t == 6) begin
                chk(rdy_n == 1'b0 && result == expect_word(6, 1'b1, 1'b1, 3'd2),
                    "R9 error flagged", result, expect_word(6, 1'b1, 1'b1, 3'd2));
            end else if (t == 10) begin
                chk(rdy_n == 1'b0 && result == expect_word(10, 1'b1, 1'b0, 3'd3),
                    "R9 error cleared", result, expect_word(10, 1'b1, 1'b0, 3'd3));
            end else begin
                chk(rdy_n == 1'b1, "R9 partial ticks discarded", {31'd0, rdy_n}, 32'd1);
            end
            gap();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule